// File: doc/BRIEF.md
# Button, LED and Hex Display Port

This block is a small register bank that a processor reaches over an 8-bit bidirectional data bus, qualified by chip-select, output-enable, write-enable and an address. A read returns either the state of fifteen push buttons, split across two addresses, or eight slide switches. A write stores one byte into one of four byte registers. Two of them make up a 16-bit word that drives sixteen discrete LEDs. The other two make up a 16-bit value that a multiplexed four-digit seven-segment display shows in hexadecimal.

The block contains the tri-state bus driver, the read selector, the write registers, the nibble-to-segment decoder and the digit scanner. Button and switch inputs are taken as clean, synchronous levels. A store operation on the bus may last several clocks. The block samples the write on the single clock in which the strobe is high, which is the first cycle of that operation.

Top module: `panel_port`

## Requirements
- R1: The block drives `bus_data` only while `cs` and `oe` are both high. At all other times it releases the bus to high impedance, so another driver's value is seen unchanged.
- R2: A read whose address low bits are 00 returns buttons 7 down to 0, with button k on bus bit k.
- R3: A read whose address low bits are 01 returns a zero in bit 7 and buttons 14 down to 8 in bits 6 down to 0.
- R4: A read whose address low bits are 10 or 11 returns the eight switch inputs, with switch k on bus bit k.
- R5: A write takes place at a rising clock edge where `cs` and `we` are high and `oe` is low. Address 4 loads `led_out[7:0]` and address 5 loads `led_out[15:8]`. The new value is visible after that edge.
- R6: A write to address 6 loads bits 7..0 of the display value, and a write to address 7 loads bits 15..8.
- R7: A write strobe has no effect when `cs` is low, when `oe` is high, or when the address is 0 to 3. In those cases neither the LED word nor the display value changes.
- R8: Each displayed nibble is decoded to active-low segments, with `seg_n[0]` as segment a through `seg_n[6]` as segment g. The active-high patterns in gfedcba order for 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R9: Exactly one bit of `dig_n` is low. When `dig_n[k]` is low, the segments show display bits 4k+3..4k. The scan moves from digit k to digit k+1 (wrapping from 3 to 0) after every `PRESCALE` clock edges. After k edges out of reset, digit (k / PRESCALE) mod 4 is selected.
- R10: A synchronous reset clears the LED word and the display value to zero and selects digit 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select |
| oe | input | 1 | Output enable (read) |
| we | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Register address |
| bus_data | inout | DATA_W | Bidirectional data bus |
| btn | input | NUM_BTN | Push-button levels, button k on bit k |
| sw | input | DATA_W | Slide-switch levels |
| led_out | output | LED_W | LED drive word |
| seg_n | output | 7 | Active-low segments a..g |
| dig_n | output | NUM_DIGITS | Active-low digit enables |

## Verification
Reads are purely combinational, so the bench drives `cs`, `oe` and the address on a falling edge and samples the bus a nanosecond later, before any clock edge. Writes are due one edge after the strobe: the bench raises the strobe on a falling edge, drops it on the next one, and only then compares the LED word and the display against its own model. The digit position follows the count of non-reset rising edges. The bench keeps that count itself and derives the expected digit as count / PRESCALE mod 4 at every falling-edge sample, so no check depends on where the scan happens to be.

// File: rtl/panel_pkg.sv
package panel_pkg;

   localparam int unsigned SEG_COUNT = 7;
   localparam int unsigned NIB_W     = 4;

   typedef enum logic [1:0] {
      RSEL_BTN_LO = 2'b00,
      RSEL_BTN_HI = 2'b01,
      RSEL_SW_A   = 2'b10,
      RSEL_SW_B   = 2'b11
   } rd_sel_e;

endpackage

// File: rtl/panel_bus_if.sv
module panel_bus_if #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NUM_BTN = 15
) (
   input  logic              cs,
   input  logic              oe,
   input  logic [1:0]        rd_addr,
   input  logic [NUM_BTN-1:0] btn,
   input  logic [DATA_W-1:0] sw,
   inout  wire  [DATA_W-1:0] bus_data,
   output logic [DATA_W-1:0] wr_data
);
   import panel_pkg::*;

   localparam int unsigned HI_W  = NUM_BTN - DATA_W;
   localparam int unsigned PAD_W = DATA_W - HI_W;

   if (NUM_BTN <= DATA_W || NUM_BTN >= 2 * DATA_W) begin : g_bad_btn
      $error("panel_bus_if: NUM_BTN must lie strictly between DATA_W and 2*DATA_W");
   end

   logic [DATA_W-1:0] rd_byte;
   logic              drive;
   rd_sel_e           sel;

   assign sel = rd_sel_e'(rd_addr);

   always_comb begin
      unique case (sel)
         RSEL_BTN_LO: rd_byte = btn[DATA_W-1:0];
         RSEL_BTN_HI: rd_byte = {{PAD_W{1'b0}}, btn[NUM_BTN-1:DATA_W]};
         default:     rd_byte = sw;
      endcase
   end

   assign drive    = cs & oe;
   assign bus_data = drive ? rd_byte : {DATA_W{1'bz}};
   assign wr_data  = bus_data;

endmodule

// File: rtl/panel_wr_regs.sv
module panel_wr_regs #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned BASE   = 4,
   parameter int unsigned NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [DATA_W*NBYTES-1:0] regs
);

   if (BASE + NBYTES > (1 << ADDR_W)) begin : g_bad_map
      $error("panel_wr_regs: register window does not fit the address space");
   end

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + i);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (wr_en && addr == MY_ADDR)
            q <= wr_data;
      end
      assign regs[i*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/panel_hex_seg.sv
module panel_hex_seg
   import panel_pkg::*;
(
   input  logic [NIB_W-1:0]     nib,
   output logic [SEG_COUNT-1:0] seg_n
);
   logic [SEG_COUNT-1:0] on;

   // on[6:0] = g f e d c b a, active high
   always_comb begin
      unique case (nib)
         4'h0: on = 7'h3F;
         4'h1: on = 7'h06;
         4'h2: on = 7'h5B;
         4'h3: on = 7'h4F;
         4'h4: on = 7'h66;
         4'h5: on = 7'h6D;
         4'h6: on = 7'h7D;
         4'h7: on = 7'h07;
         4'h8: on = 7'h7F;
         4'h9: on = 7'h6F;
         4'hA: on = 7'h77;
         4'hB: on = 7'h7C;
         4'hC: on = 7'h39;
         4'hD: on = 7'h5E;
         4'hE: on = 7'h79;
         default: on = 7'h71;
      endcase
   end

   assign seg_n = ~on;

endmodule

// File: rtl/panel_scan.sv
module panel_scan #(
   parameter int unsigned NUM_DIGITS = 4,
   parameter int unsigned PRESCALE   = 1000
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [4*NUM_DIGITS-1:0] value,
   output logic [NUM_DIGITS-1:0]   dig_n,
   output logic [3:0]              nib
);
   localparam int unsigned IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
   localparam int unsigned CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   if (NUM_DIGITS < 2) begin : g_bad_dig
      $error("panel_scan: NUM_DIGITS must be at least 2");
   end
   if (PRESCALE < 1) begin : g_bad_pre
      $error("panel_scan: PRESCALE must be at least 1");
   end

   logic             step;
   logic [IDX_W-1:0] idx;

   if (PRESCALE == 1) begin : g_no_pre
      assign step = 1'b1;
   end else begin : g_pre
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (rst || cnt == CNT_W'(PRESCALE - 1))
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
      assign step = (cnt == CNT_W'(PRESCALE - 1));
   end

   always_ff @(posedge clk) begin
      if (rst)
         idx <= '0;
      else if (step)
         idx <= (idx == IDX_W'(NUM_DIGITS - 1)) ? '0 : idx + 1'b1;
   end

   assign dig_n = ~(NUM_DIGITS'(1) << idx);
   assign nib   = value[idx*4 +: 4];

endmodule

// File: rtl/panel_port.sv
module panel_port #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned NUM_BTN    = 15,
   parameter int unsigned LED_W      = 16,
   parameter int unsigned NUM_DIGITS = 4,
   parameter int unsigned WR_BASE    = 4,
   parameter int unsigned PRESCALE   = 1000
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cs,
   input  logic                  oe,
   input  logic                  we,
   input  logic [ADDR_W-1:0]     addr,
   inout  wire  [DATA_W-1:0]     bus_data,
   input  logic [NUM_BTN-1:0]    btn,
   input  logic [DATA_W-1:0]     sw,
   output logic [LED_W-1:0]      led_out,
   output logic [6:0]            seg_n,
   output logic [NUM_DIGITS-1:0] dig_n
);
   localparam int unsigned DISP_W    = 4 * NUM_DIGITS;
   localparam int unsigned LED_BYTES = LED_W / DATA_W;
   localparam int unsigned DSP_BYTES = DISP_W / DATA_W;
   localparam int unsigned NBYTES    = LED_BYTES + DSP_BYTES;
   localparam int unsigned REG_W     = NBYTES * DATA_W;

   if (LED_W % DATA_W != 0 || DISP_W % DATA_W != 0) begin : g_bad_words
      $error("panel_port: LED and display widths must be whole bytes");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("panel_port: ADDR_W must be at least 2");
   end

   logic [DATA_W-1:0] wr_data;
   logic              wr_en;
   logic [REG_W-1:0]  regs;
   logic [3:0]        nib;

   assign wr_en = cs & we & ~oe;

   panel_bus_if #(
      .DATA_W  (DATA_W),
      .NUM_BTN (NUM_BTN)
   ) u_bus (
      .cs       (cs),
      .oe       (oe),
      .rd_addr  (addr[1:0]),
      .btn      (btn),
      .sw       (sw),
      .bus_data (bus_data),
      .wr_data  (wr_data)
   );

   panel_wr_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .BASE   (WR_BASE),
      .NBYTES (NBYTES)
   ) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .regs    (regs)
   );

   assign led_out = regs[LED_W-1:0];

   panel_scan #(
      .NUM_DIGITS (NUM_DIGITS),
      .PRESCALE   (PRESCALE)
   ) u_scan (
      .clk   (clk),
      .rst   (rst),
      .value (regs[LED_W +: DISP_W]),
      .dig_n (dig_n),
      .nib   (nib)
   );

   panel_hex_seg u_seg (
      .nib   (nib),
      .seg_n (seg_n)
   );

endmodule

// File: rtl/panel_port_chk.sv
module panel_port_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned LED_W      = 16,
   parameter int unsigned NUM_DIGITS = 4
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  cs,
   input logic                  oe,
   input logic                  we,
   input logic [ADDR_W-1:0]     addr,
   input logic [DATA_W-1:0]     bus_data,
   input logic [LED_W-1:0]      led_out,
   input logic [NUM_DIGITS-1:0] dig_n
);
   logic strobe;
   assign strobe = cs & we & ~oe;

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (led_out == '0 && dig_n == ~NUM_DIGITS'(1)));

   // R5
   led_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe && addr == ADDR_W'(4)) |=> led_out[7:0] == $past(bus_data));

   // R5
   led_hi_write_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe && addr == ADDR_W'(5)) |=> led_out[15:8] == $past(bus_data));

   // R7
   led_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(strobe && (addr == ADDR_W'(4) || addr == ADDR_W'(5))) |=> $stable(led_out));

   // R3
   btn_hi_pad_chk: assert property (@(posedge clk) disable iff (rst)
      (cs && oe && addr[1:0] == 2'b01) |-> bus_data[DATA_W-1] == 1'b0);

   // R9
   one_digit_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(~dig_n) == 1);

endmodule

bind panel_port panel_port_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .LED_W      (LED_W),
   .NUM_DIGITS (NUM_DIGITS)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cs       (cs),
   .oe       (oe),
   .we       (we),
   .addr     (addr),
   .bus_data (bus_data),
   .led_out  (led_out),
   .dig_n    (dig_n)
);

// File: tb/panel_port_tb.sv
module panel_port_tb;
   localparam int P = 3;

   logic        clk = 0;
   logic        rst = 1;
   logic        cs = 0, oe = 0, we = 0;
   logic [2:0]  addr = '0;
   logic [14:0] btn = '0;
   logic [7:0]  sw = '0;
   logic        tb_en = 0;
   logic [7:0]  tb_val = '0;
   wire  [7:0]  bus_data;
   logic [15:0] led_out;
   logic [6:0]  seg_n;
   logic [3:0]  dig_n;

   int          n_chk = 0, n_bad = 0;
   int unsigned cyc = 0;
   logic [15:0] m_led = '0, m_disp = '0;
   bit          done = 0;

   assign bus_data = tb_en ? tb_val : 8'hzz;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   panel_port #(.PRESCALE(P)) u_dut (
      .clk(clk), .rst(rst), .cs(cs), .oe(oe), .we(we), .addr(addr),
      .bus_data(bus_data), .btn(btn), .sw(sw),
      .led_out(led_out), .seg_n(seg_n), .dig_n(dig_n)
   );

   function automatic logic [6:0] exp_seg(input logic [3:0] n);
      logic [6:0] on;
      case (n)
         4'h0: on = 7'h3F; 4'h1: on = 7'h06; 4'h2: on = 7'h5B; 4'h3: on = 7'h4F;
         4'h4: on = 7'h66; 4'h5: on = 7'h6D; 4'h6: on = 7'h7D; 4'h7: on = 7'h07;
         4'h8: on = 7'h7F; 4'h9: on = 7'h6F; 4'hA: on = 7'h77; 4'hB: on = 7'h7C;
         4'hC: on = 7'h39; 4'hD: on = 7'h5E; 4'hE: on = 7'h79; default: on = 7'h71;
      endcase
      return ~on;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_display(input string req);
      int k;
      k = (cyc / P) % 4;
      check({req, " digit"}, {28'd0, dig_n}, {28'd0, ~(4'b0001 << k)});
      check({req, " seg"}, {25'd0, seg_n}, {25'd0, exp_seg(m_disp[k*4 +: 4])});
   endtask

   // strobe for one clock, then release; sample after the write edge
   task automatic bus_write(input logic [2:0] a, input logic [7:0] v,
                            input logic c, input logic o);
      @(negedge clk);
      cs = c; oe = o; we = 1; addr = a; tb_en = !o; tb_val = v;
      @(negedge clk);
      cs = 0; oe = 0; we = 0; tb_en = 0;
      #1;
   endtask

   task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      cs = 1; oe = 1; we = 0; addr = a;
      #1 check(req, {24'd0, bus_data}, {24'd0, exp});
      cs = 0; oe = 0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      #1;
      // R10 reset state
      check("R10 led", {16'd0, led_out}, 32'd0);
      check_display("R10");

      // R2 R3 R4: exhaustive over button walks and switch patterns
      for (int i = 0; i < 15; i++) begin
         btn = 15'(1) << i; sw = 8'(1 << (i % 8));
         bus_read(3'd0, btn[7:0], "R2");
         bus_read(3'd1, {1'b0, btn[14:8]}, "R3");
         bus_read(3'd2, sw, "R4");
         bus_read(3'd3, sw, "R4");
      end
      btn = 15'h7FFF; sw = 8'hC3;
      for (int a = 0; a < 8; a++) begin
         bus_read(3'(a), (a % 4 == 0) ? 8'hFF : (a % 4 == 1) ? 8'h7F : 8'hC3, "R2 R3 R4 full");
      end

      // R1: bus released when not reading; tb value seen unchanged
      @(negedge clk); cs = 1; oe = 0; tb_en = 1; tb_val = 8'hA5;
      #1 check("R1 cs only", {24'd0, bus_data}, 32'hA5);
      @(negedge clk); cs = 0; oe = 1; tb_val = 8'h5A;
      #1 check("R1 oe only", {24'd0, bus_data}, 32'h5A);
      @(negedge clk); cs = 0; oe = 0; tb_val = 8'h3C;
      #1 check("R1 idle", {24'd0, bus_data}, 32'h3C);
      tb_en = 0;

      // R5: every byte value into both LED halves
      for (int v = 0; v < 256; v++) begin
         bus_write(3'd4, 8'(v), 1, 0); m_led[7:0] = 8'(v);
         check("R5 lo", {16'd0, led_out}, {16'd0, m_led});
         bus_write(3'd5, 8'(255 - v), 1, 0); m_led[15:8] = 8'(255 - v);
         check("R5 hi", {16'd0, led_out}, {16'd0, m_led});
      end

      // R6 R8: every nibble on every digit
      for (int n = 0; n < 16; n++) begin
         bus_write(3'd6, {4'(n), 4'(n)}, 1, 0); m_disp[7:0] = {4'(n), 4'(n)};
         bus_write(3'd7, {4'(n), 4'(n)}, 1, 0); m_disp[15:8] = {4'(n), 4'(n)};
         for (int j = 0; j < 4 * P; j++) begin
            check_display("R8");
            @(negedge clk); #1;
         end
      end

      // R6 R9: distinct nibble per digit, follow the scan
      bus_write(3'd6, 8'h1E, 1, 0); m_disp[7:0] = 8'h1E;
      bus_write(3'd7, 8'h9B, 1, 0); m_disp[15:8] = 8'h9B;
      for (int j = 0; j < 8 * P + 1; j++) begin
         check_display("R6 R9");
         @(negedge clk); #1;
      end

      // R7: ignored strobes
      for (int a = 0; a < 8; a++) begin
         bus_write(3'(a), 8'h00, 0, 0);
         check("R7 cs low", {16'd0, led_out}, {16'd0, m_led});
         check_display("R7 cs low");
         bus_write(3'(a), 8'h00, 1, 1);
         check("R7 oe high", {16'd0, led_out}, {16'd0, m_led});
         check_display("R7 oe high");
      end
      for (int a = 0; a < 4; a++) begin
         bus_write(3'(a), 8'h00, 1, 0);
         check("R7 low addr", {16'd0, led_out}, {16'd0, m_led});
         check_display("R7 low addr");
      end

      // R10: reset mid-scan
      repeat (2) @(negedge clk);
      rst = 1;
      @(negedge clk);
      rst = 0; m_led = '0; m_disp = '0;
      #1;
      check("R10 led clear", {16'd0, led_out}, 32'd0);
      check("R10 digit0", {28'd0, dig_n}, 32'hE);
      check("R10 seg zero", {25'd0, seg_n}, {25'd0, exp_seg(4'h0)});
      for (int j = 0; j < 4 * P; j++) begin
         check_display("R10 scan");
         @(negedge clk); #1;
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule